// File: doc/BRIEF.md
# Staged Peripheral Reset Release Sequencer

After power-up this block takes a board's peripherals out of reset one at a time, in a fixed order. It starts with every peripheral held in reset, audio muted and interrupts inhibited. It then releases each peripheral in turn and gives each one its own settling time, counted in whole milliseconds by a prescaler. Some steps advance only when an external agent reports completion: the FPGA program load, the shared-RAM check, the handshakes with the secondary controller and the DSP, the mute command, the serial DAC configuration and the receiver initialization.

The reset lines use mixed polarities. The USB, DSP, FPGA and DAC/receiver resets are active-low, and the secondary-controller reset is active-high. Each wait on an external agent has a timeout. If the agent does not answer in time, the sequencer halts with an error flag and a code for the failing step, and leaves every later reset asserted. The sequencer drops mute and interrupt inhibit only when the whole sequence has finished. A synchronous restart returns it to the all-reset state.

Top module: `pseq_top`

## Requirements
- R1: While `rst_ni` is low, mute and interrupt inhibit are high and every peripheral is held in reset: `sub_rst_o`=1, and `usb_rst_no`, `dsp_rst_no`, `fpga_rst_no`, `dac_rst_no` are 0. The secondary clock enable, RAM enable, all request lines, `ready_o` and `error_o` are 0.
- R2: After the debounce wait, the USB reset line goes high and the secondary clock enable goes high, in the same cycle.
- R3: After the clock-settle wait, `sub_rst_o` falls, and the secondary-controller init wait follows. `sub_rst_o` is never low while the USB reset is asserted or the secondary clock is disabled.
- R4: After the init wait, `dsp_rst_no` goes high and the DSP settle wait runs. `fpga_rst_no` goes high only after that wait has ended and `fpga_load_done_i` has been seen high, and never before `dsp_rst_no`.
- R5: After the FPGA settle wait, `ram_check_req_o` goes high. Once `ram_check_ok_i` answers, the request drops and `ram_en_o` goes high in the same cycle. `ram_en_o` stays low unless the secondary controller is out of reset and the FPGA is released.
- R6: After the RAM settle wait, `sub_hs_req_o` goes high. After its acknowledge, `mute_cmd_req_o` goes high. Each request holds until it is acknowledged, and each acknowledge advances the sequence two cycles after its request was raised.
- R7: After the mute-command acknowledge, `dac_rst_no` goes high. After the DAC settle wait, `dac_cfg_start_o` pulses for exactly one cycle, and the sequencer then waits for `dac_cfg_done_i`.
- R8: After DAC configuration finishes, `dsp_hs_req_o` goes high. After its acknowledge, `rx_init_req_o` goes high until `rx_init_done_i` answers.
- R9: After receiver initialization, `ready_o` rises, and mute and interrupt inhibit fall in the same cycle. This state holds until restart or reset.
- R10: Each timed wait of N ms lasts N*`CYC_PER_MS`+1 cycles between the output changes that bound it. The waits are 100 ms debounce, 10 ms clock settle, 10 ms init, 100 ms DSP, 100 ms FPGA, 10 ms RAM and 100 ms DAC.
- R11: If an external wait gets no answer within `TIMEOUT_MS`, `error_o` rises one timeout period (plus one cycle) after the step began. `err_step_o` then gives the step: 5 FPGA load, 7 RAM check, 9 secondary handshake, 10 mute command, 12 DAC configuration, 13 DSP handshake, 14 receiver init. All requests drop, resets not yet released stay asserted, `ram_en_o` stays low if not yet enabled, and mute and inhibit stay high.
- R12: Once raised, `error_o` and `err_step_o` hold, and late done or acknowledge inputs are ignored, until restart or reset.
- R13: A one-cycle `restart_i` returns every output to the R1 state two cycles later and clears the error. The sequence then runs again from the debounce wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| restart_i | input | 1 | Synchronous restart of the sequence |
| fpga_load_done_i | input | 1 | FPGA program load complete |
| ram_check_ok_i | input | 1 | Shared-RAM check passed |
| sub_hs_ack_i | input | 1 | Secondary controller handshake acknowledge |
| mute_cmd_ack_i | input | 1 | Mute command acknowledged |
| dac_cfg_done_i | input | 1 | Serial DAC configuration finished |
| dsp_hs_ack_i | input | 1 | DSP handshake acknowledge |
| rx_init_done_i | input | 1 | Receiver initialization finished |
| mute_o | output | 1 | Audio mute, high = muted |
| irq_inhibit_o | output | 1 | Interrupt inhibit, high = inhibited |
| usb_rst_no | output | 1 | USB interface reset, active low |
| sub_rst_o | output | 1 | Secondary controller reset, active high |
| sub_clk_en_o | output | 1 | Secondary controller clock enable |
| dsp_rst_no | output | 1 | DSP reset, active low |
| fpga_rst_no | output | 1 | FPGA reset, active low |
| dac_rst_no | output | 1 | DAC and receiver reset, active low |
| ram_en_o | output | 1 | Shared-RAM access enable |
| ram_check_req_o | output | 1 | Request for the shared-RAM check |
| sub_hs_req_o | output | 1 | Secondary controller handshake request |
| mute_cmd_req_o | output | 1 | Request to send the mute command |
| dac_cfg_start_o | output | 1 | One-cycle start strobe to the DAC configurator |
| dsp_hs_req_o | output | 1 | DSP handshake request |
| rx_init_req_o | output | 1 | Receiver initialization request |
| ready_o | output | 1 | Sequence complete |
| error_o | output | 1 | Sequence halted on a timeout |
| err_step_o | output | 4 | Code of the step that timed out |

## Verification
The main pattern lets every external agent answer at once. It walks the full order and measures the interval between successive output changes, which separates a wrong order from a wrong settling time. A second pattern withholds the FPGA load completion, and a third withholds the RAM check pass. Between them they show that a timeout freezes the released resets at the failing step and reports the correct step code, and that a late completion cannot revive a halted sequence. Restart taken from both the finished state and the error state, plus an asynchronous reset taken mid-error, show that every line returns to its power-on level.

// File: rtl/pseq_pkg.sv
package pseq_pkg;
  // Step order is behaviour: outputs decode from it and error codes report it.
  typedef enum logic [3:0] {
    ST_PWRON       = 4'd0,
    ST_DEBOUNCE    = 4'd1,
    ST_SUB_CLK     = 4'd2,
    ST_SUB_INIT    = 4'd3,
    ST_DSP_SETTLE  = 4'd4,
    ST_FPGA_LOAD   = 4'd5,
    ST_FPGA_SETTLE = 4'd6,
    ST_RAM_CHECK   = 4'd7,
    ST_RAM_SETTLE  = 4'd8,
    ST_SUB_HS      = 4'd9,
    ST_MUTE_CMD    = 4'd10,
    ST_DAC_SETTLE  = 4'd11,
    ST_DAC_CFG     = 4'd12,
    ST_DSP_HS      = 4'd13,
    ST_RX_INIT     = 4'd14,
    ST_DONE        = 4'd15
  } step_e;

  localparam int NUM_REQ = 5;
endpackage

// File: rtl/pseq_ms_timer.sv
module pseq_ms_timer #(
  parameter int CYC_PER_MS = 50000,
  parameter int MS_W       = 10
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic [MS_W-1:0] ms_i,
  output logic            expired_o
);
  localparam int PRE_W = (CYC_PER_MS > 1) ? $clog2(CYC_PER_MS) : 1;
  localparam logic [PRE_W-1:0] PRE_TOP = PRE_W'(CYC_PER_MS - 1);

  logic [PRE_W-1:0] pre_q;
  logic [MS_W-1:0]  ms_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      ms_q  <= '0;
    end else if (load_i) begin
      pre_q <= PRE_TOP;
      ms_q  <= ms_i;
    end else if (ms_q != '0) begin
      if (pre_q == '0) begin
        pre_q <= PRE_TOP;
        ms_q  <= ms_q - 1'b1;
      end else begin
        pre_q <= pre_q - 1'b1;
      end
    end
  end

  assign expired_o = (ms_q == '0);
endmodule

// File: rtl/pseq_fsm.sv
module pseq_fsm
  import pseq_pkg::*;
#(
  parameter int MS_W        = 10,
  parameter int DEBOUNCE_MS = 100,
  parameter int SUB_CLK_MS  = 10,
  parameter int SUB_INIT_MS = 10,
  parameter int DSP_MS      = 100,
  parameter int FPGA_MS     = 100,
  parameter int RAM_MS      = 10,
  parameter int DAC_MS      = 100,
  parameter int TIMEOUT_MS  = 200
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            restart_i,
  input  logic            expired_i,
  input  logic            fpga_load_done_i,
  input  logic            ram_check_ok_i,
  input  logic            sub_hs_ack_i,
  input  logic            mute_cmd_ack_i,
  input  logic            dac_cfg_done_i,
  input  logic            dsp_hs_ack_i,
  input  logic            rx_init_done_i,
  output step_e           step_o,
  output logic            err_o,
  output logic            load_o,
  output logic [MS_W-1:0] load_ms_o
);
  step_e step_q, step_d;
  logic  err_q, err_d;
  logic  ack;

  function automatic logic [MS_W-1:0] wait_ms(step_e s);
    case (s)
      ST_DEBOUNCE:    return MS_W'(DEBOUNCE_MS);
      ST_SUB_CLK:     return MS_W'(SUB_CLK_MS);
      ST_SUB_INIT:    return MS_W'(SUB_INIT_MS);
      ST_DSP_SETTLE:  return MS_W'(DSP_MS);
      ST_FPGA_SETTLE: return MS_W'(FPGA_MS);
      ST_RAM_SETTLE:  return MS_W'(RAM_MS);
      ST_DAC_SETTLE:  return MS_W'(DAC_MS);
      ST_PWRON, ST_DONE: return '0;
      default:        return MS_W'(TIMEOUT_MS);
    endcase
  endfunction

  always_comb begin
    case (step_q)
      ST_FPGA_LOAD: ack = fpga_load_done_i;
      ST_RAM_CHECK: ack = ram_check_ok_i;
      ST_SUB_HS:    ack = sub_hs_ack_i;
      ST_MUTE_CMD:  ack = mute_cmd_ack_i;
      ST_DAC_CFG:   ack = dac_cfg_done_i;
      ST_DSP_HS:    ack = dsp_hs_ack_i;
      ST_RX_INIT:   ack = rx_init_done_i;
      default:      ack = 1'b0;
    endcase
  end

  always_comb begin
    step_d = step_q;
    err_d  = err_q;
    if (restart_i) begin
      step_d = ST_PWRON;
      err_d  = 1'b0;
    end else if (!err_q) begin
      case (step_q)
        ST_PWRON: step_d = ST_DEBOUNCE;
        ST_DEBOUNCE, ST_SUB_CLK, ST_SUB_INIT, ST_DSP_SETTLE,
        ST_FPGA_SETTLE, ST_RAM_SETTLE, ST_DAC_SETTLE: begin
          if (expired_i) step_d = step_e'(step_q + 4'd1);
        end
        ST_DONE: step_d = ST_DONE;
        default: begin
          if (ack)            step_d = step_e'(step_q + 4'd1);
          else if (expired_i) err_d  = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q <= ST_PWRON;
      err_q  <= 1'b0;
    end else begin
      step_q <= step_d;
      err_q  <= err_d;
    end
  end

  assign load_o    = (step_d != step_q);
  assign load_ms_o = wait_ms(step_d);
  assign step_o    = step_q;
  assign err_o     = err_q;
endmodule

// File: rtl/pseq_out_dec.sv
module pseq_out_dec
  import pseq_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  step_e              step_i,
  input  logic               err_i,
  output logic               mute_o,
  output logic               irq_inhibit_o,
  output logic               usb_rst_no,
  output logic               sub_rst_o,
  output logic               sub_clk_en_o,
  output logic               dsp_rst_no,
  output logic               fpga_rst_no,
  output logic               dac_rst_no,
  output logic               ram_en_o,
  output logic [NUM_REQ-1:0] req_o,
  output logic               dac_cfg_start_o,
  output logic               ready_o,
  output logic               error_o,
  output logic [3:0]         err_step_o
);
  localparam step_e REQ_STEP [NUM_REQ] =
    '{ST_RAM_CHECK, ST_SUB_HS, ST_MUTE_CMD, ST_DSP_HS, ST_RX_INIT};

  step_e prev_q;
  logic  fin;

  assign fin = (step_i == ST_DONE) && !err_i;

  // Release levels follow step order, so an error freezes them at the failing step.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mute_o          <= 1'b1;
      irq_inhibit_o   <= 1'b1;
      usb_rst_no      <= 1'b0;
      sub_rst_o       <= 1'b1;
      sub_clk_en_o    <= 1'b0;
      dsp_rst_no      <= 1'b0;
      fpga_rst_no     <= 1'b0;
      dac_rst_no      <= 1'b0;
      ram_en_o        <= 1'b0;
      dac_cfg_start_o <= 1'b0;
      ready_o         <= 1'b0;
      error_o         <= 1'b0;
      err_step_o      <= '0;
      prev_q          <= ST_PWRON;
    end else begin
      mute_o          <= !fin;
      irq_inhibit_o   <= !fin;
      usb_rst_no      <= step_i >= ST_SUB_CLK;
      sub_clk_en_o    <= step_i >= ST_SUB_CLK;
      sub_rst_o       <= step_i <  ST_SUB_INIT;
      dsp_rst_no      <= step_i >= ST_DSP_SETTLE;
      fpga_rst_no     <= step_i >= ST_FPGA_SETTLE;
      ram_en_o        <= step_i >= ST_RAM_SETTLE;
      dac_rst_no      <= step_i >= ST_DAC_SETTLE;
      dac_cfg_start_o <= (step_i == ST_DAC_CFG) && (prev_q != ST_DAC_CFG) && !err_i;
      ready_o         <= fin;
      error_o         <= err_i;
      err_step_o      <= err_i ? step_i : 4'd0;
      prev_q          <= step_i;
    end
  end

  for (genvar g = 0; g < NUM_REQ; g++) begin : g_req
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) req_o[g] <= 1'b0;
      else         req_o[g] <= (step_i == REQ_STEP[g]) && !err_i;
    end
  end
endmodule

// File: rtl/pseq_top.sv
module pseq_top
  import pseq_pkg::*;
#(
  parameter int CYC_PER_MS  = 50000,
  parameter int DEBOUNCE_MS = 100,
  parameter int SUB_CLK_MS  = 10,
  parameter int SUB_INIT_MS = 10,
  parameter int DSP_MS      = 100,
  parameter int FPGA_MS     = 100,
  parameter int RAM_MS      = 10,
  parameter int DAC_MS      = 100,
  parameter int TIMEOUT_MS  = 200
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       restart_i,
  input  logic       fpga_load_done_i,
  input  logic       ram_check_ok_i,
  input  logic       sub_hs_ack_i,
  input  logic       mute_cmd_ack_i,
  input  logic       dac_cfg_done_i,
  input  logic       dsp_hs_ack_i,
  input  logic       rx_init_done_i,
  output logic       mute_o,
  output logic       irq_inhibit_o,
  output logic       usb_rst_no,
  output logic       sub_rst_o,
  output logic       sub_clk_en_o,
  output logic       dsp_rst_no,
  output logic       fpga_rst_no,
  output logic       dac_rst_no,
  output logic       ram_en_o,
  output logic       ram_check_req_o,
  output logic       sub_hs_req_o,
  output logic       mute_cmd_req_o,
  output logic       dac_cfg_start_o,
  output logic       dsp_hs_req_o,
  output logic       rx_init_req_o,
  output logic       ready_o,
  output logic       error_o,
  output logic [3:0] err_step_o
);
  // Sum of all waits bounds any single load value.
  localparam int MS_W = $clog2(DEBOUNCE_MS + SUB_CLK_MS + SUB_INIT_MS + DSP_MS +
                               FPGA_MS + RAM_MS + DAC_MS + TIMEOUT_MS + 1);

  step_e              step;
  logic               err;
  logic               load;
  logic [MS_W-1:0]    load_ms;
  logic               expired;
  logic [NUM_REQ-1:0] req;

  pseq_ms_timer #(
    .CYC_PER_MS (CYC_PER_MS),
    .MS_W       (MS_W)
  ) i_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .ms_i      (load_ms),
    .expired_o (expired)
  );

  pseq_fsm #(
    .MS_W        (MS_W),
    .DEBOUNCE_MS (DEBOUNCE_MS),
    .SUB_CLK_MS  (SUB_CLK_MS),
    .SUB_INIT_MS (SUB_INIT_MS),
    .DSP_MS      (DSP_MS),
    .FPGA_MS     (FPGA_MS),
    .RAM_MS      (RAM_MS),
    .DAC_MS      (DAC_MS),
    .TIMEOUT_MS  (TIMEOUT_MS)
  ) i_fsm (
    .clk_i            (clk_i),
    .rst_ni           (rst_ni),
    .restart_i        (restart_i),
    .expired_i        (expired),
    .fpga_load_done_i (fpga_load_done_i),
    .ram_check_ok_i   (ram_check_ok_i),
    .sub_hs_ack_i     (sub_hs_ack_i),
    .mute_cmd_ack_i   (mute_cmd_ack_i),
    .dac_cfg_done_i   (dac_cfg_done_i),
    .dsp_hs_ack_i     (dsp_hs_ack_i),
    .rx_init_done_i   (rx_init_done_i),
    .step_o           (step),
    .err_o            (err),
    .load_o           (load),
    .load_ms_o        (load_ms)
  );

  pseq_out_dec i_out (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .step_i          (step),
    .err_i           (err),
    .mute_o          (mute_o),
    .irq_inhibit_o   (irq_inhibit_o),
    .usb_rst_no      (usb_rst_no),
    .sub_rst_o       (sub_rst_o),
    .sub_clk_en_o    (sub_clk_en_o),
    .dsp_rst_no      (dsp_rst_no),
    .fpga_rst_no     (fpga_rst_no),
    .dac_rst_no      (dac_rst_no),
    .ram_en_o        (ram_en_o),
    .req_o           (req),
    .dac_cfg_start_o (dac_cfg_start_o),
    .ready_o         (ready_o),
    .error_o         (error_o),
    .err_step_o      (err_step_o)
  );

  assign ram_check_req_o = req[0];
  assign sub_hs_req_o    = req[1];
  assign mute_cmd_req_o  = req[2];
  assign dsp_hs_req_o    = req[3];
  assign rx_init_req_o   = req[4];
endmodule

// File: rtl/pseq_checker.sv
module pseq_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       restart_i,
  input logic       fpga_load_done_i,
  input logic       mute_o,
  input logic       irq_inhibit_o,
  input logic       usb_rst_no,
  input logic       sub_rst_o,
  input logic       sub_clk_en_o,
  input logic       dsp_rst_no,
  input logic       fpga_rst_no,
  input logic       dac_rst_no,
  input logic       ram_en_o,
  input logic       ram_check_req_o,
  input logic       sub_hs_req_o,
  input logic       mute_cmd_req_o,
  input logic       dac_cfg_start_o,
  input logic       dsp_hs_req_o,
  input logic       rx_init_req_o,
  input logic       ready_o,
  input logic       error_o,
  input logic [3:0] err_step_o
);
  p_sub_after_usb_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sub_rst_o |-> (usb_rst_no && sub_clk_en_o));

  p_fpga_after_dsp_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fpga_rst_no |-> dsp_rst_no);

  p_fpga_needs_load_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fpga_rst_no) |-> $past(fpga_load_done_i, 2));

  p_ram_en_gated_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_en_o |-> (!sub_rst_o && fpga_rst_no));

  p_dac_after_ram_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dac_rst_no |-> ram_en_o);

  p_start_one_cycle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dac_cfg_start_o |=> !dac_cfg_start_o);

  p_ready_unmutes_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (!mute_o && !irq_inhibit_o && !error_o));

  p_muted_until_ready_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |-> (mute_o && irq_inhibit_o));

  p_no_req_in_error_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    error_o |-> !(ram_check_req_o || sub_hs_req_o || mute_cmd_req_o ||
                  dsp_hs_req_o || rx_init_req_o || dac_cfg_start_o));

  p_error_holds_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (error_o && !restart_i && !$past(restart_i)) |=> (error_o && $stable(err_step_o)));
endmodule

bind pseq_top pseq_checker i_pseq_checker (
  .clk_i            (clk_i),
  .rst_ni           (rst_ni),
  .restart_i        (restart_i),
  .fpga_load_done_i (fpga_load_done_i),
  .mute_o           (mute_o),
  .irq_inhibit_o    (irq_inhibit_o),
  .usb_rst_no       (usb_rst_no),
  .sub_rst_o        (sub_rst_o),
  .sub_clk_en_o     (sub_clk_en_o),
  .dsp_rst_no       (dsp_rst_no),
  .fpga_rst_no      (fpga_rst_no),
  .dac_rst_no       (dac_rst_no),
  .ram_en_o         (ram_en_o),
  .ram_check_req_o  (ram_check_req_o),
  .sub_hs_req_o     (sub_hs_req_o),
  .mute_cmd_req_o   (mute_cmd_req_o),
  .dac_cfg_start_o  (dac_cfg_start_o),
  .dsp_hs_req_o     (dsp_hs_req_o),
  .rx_init_req_o    (rx_init_req_o),
  .ready_o          (ready_o),
  .error_o          (error_o),
  .err_step_o       (err_step_o)
);

// File: tb/test_pseq_top.sv
module test_pseq_top;
  localparam int C    = 2;
  localparam int TO   = 20;
  localparam int NPH  = 13;
  localparam int LIMIT = 2000;

  // bundle: ready err mute inh | usb sub clk dsp | fpga dac ram rreq | shs mreq dhs rx
  localparam logic [15:0] EXP [NPH] = '{
    16'b0011_0100_0000_0000,
    16'b0011_1110_0000_0000,
    16'b0011_1010_0000_0000,
    16'b0011_1011_0000_0000,
    16'b0011_1011_1000_0000,
    16'b0011_1011_1001_0000,
    16'b0011_1011_1010_0000,
    16'b0011_1011_1010_1000,
    16'b0011_1011_1010_0100,
    16'b0011_1011_1110_0000,
    16'b0011_1011_1110_0010,
    16'b0011_1011_1110_0001,
    16'b1000_1011_1110_0000
  };
  localparam int DWELL [NPH] = '{
    0, 100*C+3, 10*C+1, 10*C+1, 100*C+2, 100*C+1, 2,
    10*C+1, 2, 2, 100*C+3, 2, 2
  };
  localparam logic [15:0] P0     = 16'b0011_0100_0000_0000;
  localparam logic [15:0] ERR_FL = 16'b0111_1011_0000_0000;
  localparam logic [15:0] ERR_RM = 16'b0111_1011_1000_0000;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic restart_i = 1'b0;
  logic fpga_load_done_i = 1'b0, ram_check_ok_i = 1'b0, sub_hs_ack_i = 1'b0;
  logic mute_cmd_ack_i = 1'b0, dac_cfg_done_i = 1'b0, dsp_hs_ack_i = 1'b0;
  logic rx_init_done_i = 1'b0;
  logic mute_o, irq_inhibit_o, usb_rst_no, sub_rst_o, sub_clk_en_o, dsp_rst_no;
  logic fpga_rst_no, dac_rst_no, ram_en_o, ram_check_req_o, sub_hs_req_o;
  logic mute_cmd_req_o, dac_cfg_start_o, dsp_hs_req_o, rx_init_req_o;
  logic ready_o, error_o;
  logic [3:0] err_step_o;

  int  n_chk = 0, n_fail = 0, dac_pulses = 0;
  bit  allow_fpga = 1'b1, allow_ram = 1'b1, dac_seen = 1'b0, finished = 1'b0;

  always #10 clk = ~clk;

  pseq_top #(.CYC_PER_MS(C), .TIMEOUT_MS(TO)) i_pseq_top (
    .clk_i(clk), .rst_ni(rst_ni), .restart_i(restart_i),
    .fpga_load_done_i(fpga_load_done_i), .ram_check_ok_i(ram_check_ok_i),
    .sub_hs_ack_i(sub_hs_ack_i), .mute_cmd_ack_i(mute_cmd_ack_i),
    .dac_cfg_done_i(dac_cfg_done_i), .dsp_hs_ack_i(dsp_hs_ack_i),
    .rx_init_done_i(rx_init_done_i),
    .mute_o(mute_o), .irq_inhibit_o(irq_inhibit_o), .usb_rst_no(usb_rst_no),
    .sub_rst_o(sub_rst_o), .sub_clk_en_o(sub_clk_en_o), .dsp_rst_no(dsp_rst_no),
    .fpga_rst_no(fpga_rst_no), .dac_rst_no(dac_rst_no), .ram_en_o(ram_en_o),
    .ram_check_req_o(ram_check_req_o), .sub_hs_req_o(sub_hs_req_o),
    .mute_cmd_req_o(mute_cmd_req_o), .dac_cfg_start_o(dac_cfg_start_o),
    .dsp_hs_req_o(dsp_hs_req_o), .rx_init_req_o(rx_init_req_o),
    .ready_o(ready_o), .error_o(error_o), .err_step_o(err_step_o)
  );

  function automatic logic [15:0] bundle();
    return {ready_o, error_o, mute_o, irq_inhibit_o,
            usb_rst_no, sub_rst_o, sub_clk_en_o, dsp_rst_no,
            fpga_rst_no, dac_rst_no, ram_en_o, ram_check_req_o,
            sub_hs_req_o, mute_cmd_req_o, dsp_hs_req_o, rx_init_req_o};
  endfunction

  function automatic string tag_of(int i);
    case (i)
      0:       return "R1";
      1:       return "R2";
      2:       return "R3";
      3, 4:    return "R4";
      5, 6:    return "R5";
      7, 8:    return "R6";
      9:       return "R7";
      10, 11:  return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // External agents answer at the negedge after they see a request.
  task automatic respond();
    sub_hs_ack_i     = sub_hs_req_o;
    mute_cmd_ack_i   = mute_cmd_req_o;
    dsp_hs_ack_i     = dsp_hs_req_o;
    rx_init_done_i   = rx_init_req_o;
    ram_check_ok_i   = ram_check_req_o & allow_ram;
    fpga_load_done_i = allow_fpga;
    if (dac_cfg_start_o) begin
      dac_seen = 1'b1;
      dac_pulses++;
    end
    if (dsp_hs_req_o) dac_seen = 1'b0;
    dac_cfg_done_i = dac_seen;
  endtask

  task automatic step_wait(output logic [15:0] b, output int cyc);
    logic [15:0] prev;
    prev = bundle();
    cyc  = 0;
    do begin
      @(negedge clk);
      cyc++;
      respond();
    end while (bundle() == prev && cyc < LIMIT);
    b = bundle();
  endtask

  task automatic do_restart();
    @(negedge clk);
    restart_i = 1'b1;
    @(negedge clk);
    restart_i = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] b;
    int cyc;
    repeat (3) @(negedge clk);
    chk(bundle() == EXP[0], "R1", "reset bundle", bundle(), EXP[0]);
    chk(err_step_o == 4'd0 && !dac_cfg_start_o, "R1", "reset code", err_step_o, 0);
    rst_ni = 1'b1;

    // Table walk: every agent answers promptly.
    for (int i = 1; i < NPH; i++) begin
      step_wait(b, cyc);
      chk(b == EXP[i], tag_of(i), $sformatf("phase %0d bundle", i), b, EXP[i]);
      if (DWELL[i] != 0)
        chk(cyc == DWELL[i], "R10", $sformatf("phase %0d interval", i), cyc, DWELL[i]);
    end
    chk(dac_pulses == 1, "R7", "start strobe cycles", dac_pulses, 1);
    chk(err_step_o == 4'd0, "R9", "no error code", err_step_o, 0);
    repeat (20) @(negedge clk);
    chk(bundle() == EXP[NPH-1], "R9", "ready holds", bundle(), EXP[NPH-1]);

    // Restart from the finished state.
    do_restart();
    chk(bundle() == P0, "R13", "restart from ready", bundle(), P0);

    // FPGA load never completes.
    allow_fpga = 1'b0;
    for (int i = 1; i < 4; i++) step_wait(b, cyc);
    step_wait(b, cyc);
    chk(b == ERR_FL, "R11", "fpga timeout bundle", b, ERR_FL);
    chk(cyc == 100*C + 1 + TO*C + 1, "R11", "fpga timeout interval", cyc, 100*C + TO*C + 2);
    chk(err_step_o == 4'd5, "R11", "fpga step code", err_step_o, 5);
    allow_fpga = 1'b1;
    repeat (30) begin @(negedge clk); respond(); end
    chk(bundle() == ERR_FL, "R12", "late load done ignored", bundle(), ERR_FL);
    chk(err_step_o == 4'd5, "R12", "code held", err_step_o, 5);

    do_restart();
    chk(bundle() == P0 && err_step_o == 4'd0, "R13", "restart clears error", bundle(), P0);

    // RAM check never passes.
    allow_ram = 1'b0;
    for (int i = 1; i < 6; i++) step_wait(b, cyc);
    chk(b == EXP[5], "R5", "ram check requested", b, EXP[5]);
    step_wait(b, cyc);
    chk(b == ERR_RM, "R11", "ram timeout bundle", b, ERR_RM);
    chk(cyc == TO*C + 1, "R11", "ram timeout interval", cyc, TO*C + 1);
    chk(err_step_o == 4'd7, "R11", "ram step code", err_step_o, 7);
    chk(!ram_en_o, "R5", "ram stays disabled", ram_en_o, 0);

    // Asynchronous reset in the error state.
    @(negedge clk);
    rst_ni = 1'b0;
    #1;
    chk(bundle() == P0 && err_step_o == 4'd0, "R1", "async reset in error", bundle(), P0);
    @(negedge clk);
    rst_ni = 1'b1;
    allow_ram = 1'b1;

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule